// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block is a free-running hardware clock for precision time protocol use. Each core clock cycle is one 8 ns tick. On each tick a 40-bit nanosecond count moves forward by a fixed base step of 8. A 32-bit sub-nanosecond accumulator adds or removes one extra nanosecond whenever it carries or borrows. Software sets a sign-magnitude increment word that trims the clock's frequency in steps of 2^-32 ns per tick. The base step itself cannot be changed.

Software reaches the block through a simple word-wide register port. Reading the sub-nanosecond register captures the whole nanosecond count in a snapshot. The low and high time registers then return that frozen value, so a 40-bit time can be built from several 32-bit reads without tearing. Setting the time takes two writes. A write to the low register stages its half, and a write to the high register loads the full count in one cycle. A stop bit in the control register halts the timer.

Top module: `hw_ns_clock`

## Requirements
- R1: While running with a zero increment word, the nanosecond count advances by exactly 8 on every clock and the sub-nanosecond accumulator holds its value.
- R2: With increment bit 31 clear, bits 30:0 are added to the 32-bit accumulator on each tick. A carry out of bit 31 adds one more nanosecond to that tick's step, giving 9.
- R3: With increment bit 31 set, bits 30:0 are subtracted from the accumulator on each tick. A borrow takes one nanosecond off that tick's step, giving 7.
- R4: The nanosecond count is 40 bits wide and wraps modulo 2^40, so it passes from 2^40-1 through zero.
- R5: A read of address 0 returns the live accumulator and latches the current nanosecond count. Address 1 returns bits 31:0 of that snapshot. Address 2 returns bits 39:32 of it in bits 7:0, with bits 31:8 reading zero. Reads of addresses 1 and 2 with no fresh latch keep returning the previous snapshot.
- R6: Address 4 is the control register. Its bit 31 stops the timer when set, which freezes both count and accumulator. Clearing it lets the timer run. The register reads back as {stop, 31'b0}.
- R7: A write to address 1 stages the low 32 bits. A write to address 2 loads {wdata[7:0], staged} as the count on the next edge and clears the accumulator, and this load takes priority over the tick. Writes to address 0 have no effect.
- R8: After reset the count, accumulator, snapshot and increment word are zero, the timer is stopped, and read data and valid are zero.
- R9: Read data and its valid flag appear on the clock edge after the read strobe, holding the values from before that edge. Valid is low on cycles with no read.
- R10: Address 3 holds the increment word, which reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one 8 ns tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |

## Verification
The counter is driven with a zero trim, a positive trim and a negative trim. These separate a fixed 8 ns step from carry and borrow handling, since each gives its own count of 9 ns and 7 ns ticks. Loads just below 2^40 test the wrap. Stop periods test that both count and accumulator hold. Snapshot reads are mixed with repeated low and high reads and idle gaps, which shows whether those reads come from the latch or from the live count. A long seeded random mix of reads, loads, trim and stop writes is compared every read against a bench model built from the requirements.

// File: rtl/hnc_pkg.sv
package hnc_pkg;
    parameter int NS_W      = 40;
    parameter int FRAC_W    = 32;
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 3;
    parameter int BASE_STEP = 8;

    localparam int HI_W = NS_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_FRAC = 3'd0,
        A_LO   = 3'd1,
        A_HI   = 3'd2,
        A_INCR = 3'd3,
        A_CTRL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } core_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] incr;
        logic              stop;
        logic [DATA_W-1:0] stage_lo;
        logic [NS_W-1:0]   snap;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } regs_state_t;
endpackage

// File: rtl/hnc_tick_core.sv
module hnc_tick_core
    import hnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] incr_i,
    input  logic              load_i,
    input  logic [NS_W-1:0]   load_ns_i,
    output logic [NS_W-1:0]   ns_o,
    output logic [FRAC_W-1:0] frac_o
);
    core_state_t st_q, st_d;

    logic              neg;
    logic [FRAC_W-1:0] mag;
    logic [FRAC_W:0]   sum_w, dif_w;
    logic [NS_W-1:0]   step;

    always_comb begin
        neg   = incr_i[DATA_W-1];
        mag   = FRAC_W'(incr_i[DATA_W-2:0]);
        sum_w = {1'b0, st_q.frac} + {1'b0, mag};
        dif_w = {1'b0, st_q.frac} - {1'b0, mag};
        if (neg)
            step = NS_W'(BASE_STEP) - NS_W'(dif_w[FRAC_W]);
        else
            step = NS_W'(BASE_STEP) + NS_W'(sum_w[FRAC_W]);

        st_d = st_q;
        if (load_i) begin
            st_d.ns   = load_ns_i;
            st_d.frac = '0;
        end else if (run_i) begin
            st_d.ns   = st_q.ns + step;
            st_d.frac = neg ? dif_w[FRAC_W-1:0] : sum_w[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ns_o   = st_q.ns;
    assign frac_o = st_q.frac;

    p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> ((st_q.ns - $past(st_q.ns)) inside {NS_W'(7), NS_W'(8), NS_W'(9)}));

    p_base_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && incr_i == '0) |=> (st_q.ns == $past(st_q.ns) + NS_W'(8) && $stable(st_q.frac)));

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> ($stable(st_q.ns) && $stable(st_q.frac)));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.ns == $past(load_ns_i) && st_q.frac == '0));

    p_no_carry_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && incr_i[DATA_W-1]) |=> ((st_q.ns - $past(st_q.ns)) != NS_W'(9)));
endmodule

// File: rtl/hnc_regs.sv
module hnc_regs
    import hnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NS_W-1:0]   ns_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [DATA_W-1:0] incr_o,
    output logic              run_o,
    output logic              load_o,
    output logic [NS_W-1:0]   load_ns_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    regs_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = re_i;
        st_d.rdata  = '0;
        if (re_i) begin
            case (addr_i)
                A_FRAC: begin
                    st_d.rdata = DATA_W'(frac_i);
                    st_d.snap  = ns_i;
                end
                A_LO:    st_d.rdata = st_q.snap[DATA_W-1:0];
                A_HI:    st_d.rdata = DATA_W'(st_q.snap[NS_W-1:DATA_W]);
                A_INCR:  st_d.rdata = st_q.incr;
                A_CTRL:  st_d.rdata = {st_q.stop, {(DATA_W-1){1'b0}}};
                default: st_d.rdata = '0;
            endcase
        end
        if (we_i) begin
            case (addr_i)
                A_LO:    st_d.stage_lo = wdata_i;
                A_INCR:  st_d.incr     = wdata_i;
                A_CTRL:  st_d.stop     = wdata_i[DATA_W-1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign incr_o    = st_q.incr;
    assign run_o     = !st_q.stop;
    assign load_o    = we_i && (addr_i == A_HI);
    assign load_ns_o = {wdata_i[HI_W-1:0], st_q.stage_lo};
    assign rdata_o   = st_q.rdata;
    assign rvalid_o  = st_q.rvalid;

    p_hi_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && addr_i == A_HI) |=> (rdata_o[DATA_W-1:HI_W] == '0));

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(re_i && addr_i == A_FRAC) |=> $stable(st_q.snap));

    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        re_i |=> rvalid_o);

    p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> (!rvalid_o && rdata_o == '0));
endmodule

// File: rtl/hw_ns_clock.sv
module hw_ns_clock
    import hnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    logic [NS_W-1:0]   ns_w, load_ns_w;
    logic [FRAC_W-1:0] frac_w;
    logic [DATA_W-1:0] incr_w;
    logic              run_w, load_w;

    hnc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (bus_we),
        .re_i      (bus_re),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .ns_i      (ns_w),
        .frac_i    (frac_w),
        .incr_o    (incr_w),
        .run_o     (run_w),
        .load_o    (load_w),
        .load_ns_o (load_ns_w),
        .rdata_o   (bus_rdata),
        .rvalid_o  (bus_rvalid)
    );

    hnc_tick_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .incr_i    (incr_w),
        .load_i    (load_w),
        .load_ns_i (load_ns_w),
        .ns_o      (ns_w),
        .frac_o    (frac_w)
    );

    p_reset_stopped_r8: assert property (@(posedge clk)
        !rst_n |=> (!bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/hw_ns_clock_tb.sv
`timescale 1ns/1ps
module hw_ns_clock_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_cmp = 0, n_bad = 0;

    logic [39:0] m_ns = '0, m_snap = '0;
    logic [31:0] m_frac = '0, m_incr = '0, m_stage = '0;
    logic        m_stop = 1'b1;

    always #4 clk = ~clk;

    hw_ns_clock u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return m_frac;
            3'd1: return m_snap[31:0];
            3'd2: return {24'h0, m_snap[39:32]};
            3'd3: return m_incr;
            3'd4: return {m_stop, 31'h0};
            default: return 32'h0;
        endcase
    endfunction

    // one tick of the model from R1..R4
    task automatic model_tick();
        logic [32:0] t;
        logic [31:0] mg;
        mg = {1'b0, m_incr[30:0]};
        if (m_incr[31]) begin
            t = {1'b0, m_frac} - {1'b0, mg};
            m_ns = m_ns + 40'd8 - {39'h0, t[32]};
        end else begin
            t = {1'b0, m_frac} + {1'b0, mg};
            m_ns = m_ns + 40'd8 + {39'h0, t[32]};
        end
        m_frac = t[31:0];
    endtask

    task automatic op(logic we, logic re, logic [2:0] a, logic [31:0] wd, string req);
        logic [31:0] er;
        logic        ld;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        er = exp_read(a);
        ld = we && a == 3'd2;
        if (re && a == 3'd0) m_snap = m_ns;
        if (ld) begin
            m_ns = {wd[7:0], m_stage};
            m_frac = '0;
        end else if (!m_stop) begin
            model_tick();
        end
        if (we && a == 3'd1) m_stage = wd;
        if (we && a == 3'd3) m_incr = wd;
        if (we && a == 3'd4) m_stop = wd[31];
        #2;
        chk({req, "/R9 valid"}, {31'h0, bus_rvalid}, {31'h0, re});
        if (re) chk(req, bus_rdata, er);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 3'd0, 32'h0, "R9 idle");
    endtask

    task automatic read_time(string req);
        op(1'b0, 1'b1, 3'd0, 32'h0, req);
        op(1'b0, 1'b1, 3'd1, 32'h0, req);
        op(1'b0, 1'b1, 3'd2, 32'h0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        #2;
        chk("R8 rvalid after reset", {31'h0, bus_rvalid}, 32'h0);
        chk("R8 rdata after reset", bus_rdata, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        idle(5);
        read_time("R8 stopped at zero");
        op(1'b0, 1'b1, 3'd3, 0, "R8 incr zero");
        op(1'b0, 1'b1, 3'd4, 0, "R8 ctrl stop");

        // R1: run with zero trim
        op(1'b1, 1'b0, 3'd4, 32'h0, "R6 run");
        idle(10);
        read_time("R1 step of 8");
        idle(3);
        read_time("R1 step of 8 again");

        // R10 + R2 positive trim
        op(1'b1, 1'b0, 3'd3, 32'h4000_0000, "R10 write");
        op(1'b0, 1'b1, 3'd3, 0, "R10 readback");
        idle(7);
        read_time("R2 carry");
        // R3 negative trim
        op(1'b1, 1'b0, 3'd3, 32'hC000_0000, "R10 write");
        idle(9);
        read_time("R3 borrow");

        // R4 wrap
        op(1'b1, 1'b0, 3'd3, 32'h0, "R10 write");
        op(1'b1, 1'b0, 3'd1, 32'hFFFF_FFF0, "R7 stage");
        op(1'b1, 1'b0, 3'd2, 32'h0000_00FF, "R7 load");
        read_time("R4 near top");
        idle(2);
        read_time("R4 wrapped");

        // R7 write to frac ignored, load clears accumulator
        op(1'b1, 1'b0, 3'd3, 32'h1234_5678, "R10 write");
        idle(4);
        op(1'b1, 1'b0, 3'd0, 32'hDEAD_BEEF, "R7 frac write");
        read_time("R7 frac unchanged");
        op(1'b1, 1'b0, 3'd1, 32'h0000_1000, "R7 stage");
        idle(3);
        op(1'b1, 1'b0, 3'd2, 32'hFFFF_FF12, "R7 load");
        read_time("R7 loaded");

        // R6 stop holds count and accumulator
        op(1'b1, 1'b0, 3'd4, 32'h8000_0000, "R6 stop");
        read_time("R6 stopped");
        idle(6);
        read_time("R6 still stopped");
        op(1'b1, 1'b0, 3'd4, 32'h0, "R6 run");

        // R5 snapshot hold without fresh latch
        op(1'b0, 1'b1, 3'd0, 0, "R5 latch");
        idle(5);
        op(1'b0, 1'b1, 3'd1, 0, "R5 old lo");
        op(1'b0, 1'b1, 3'd2, 0, "R5 old hi");
        idle(4);
        op(1'b0, 1'b1, 3'd1, 0, "R5 old lo again");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic        w, r;
            logic [2:0]  a;
            logic [31:0] d;
            w = ($urandom_range(0, 99) < 25);
            r = ($urandom_range(0, 99) < 60);
            a = 3'($urandom_range(0, 4));
            d = $urandom();
            if (w && a == 3'd4) d = ($urandom_range(0, 99) < 20) ? 32'h8000_0000 : 32'h0;
            op(w, r, a, d, "R5 random");
        end
        op(1'b1, 1'b0, 3'd4, 32'h0, "R6 run");
        read_time("R1 final");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule